// File: doc/BRIEF.md
# Reset Release and Boot Vector Sequencer

This block decides when a small 8-bit microcontroller leaves reset. It watches four reset causes: a power-on or low-voltage detect flag, an active-low external reset pin, a wake request out of STOP mode, and a crystal-enable option bit. From these it works out how long the system stays in reset, counting cycles of the internal oscillator that clocks it. While reset is held it drives a system reset to the CPU and peripherals. During that time it forces the GPIO pads to safe settings, and it returns the clock-source selection to the internal oscillator.

Once the hold time has passed and the external pin is released, the block reads the two-byte boot vector from program memory. It uses a synchronous read port with one cycle of latency. It then presents the resulting 16-bit start address on a program-counter output and pulses a one-cycle done flag. The CPU stays held until that moment.

A wake from STOP mode is lighter than a system reset. Only the watchdog-control and oscillator-control registers are cleared, through one-cycle strobes. The hold count and the vector fetch still run.

Top module: `boot_reset_ctrl`

## Requirements
- R1: While `arst_n` is low, `sys_rst_o` and `cpu_hold_o` are 1, `clk_sel_o` is 2'b00 (internal oscillator) and `mem_rd_o` is 0.
- R2: After a power-on or low-voltage reset with `xtal_opt_i`=0, counting starts on the first clock edge at which `supply_ok_i` is 1 and `lv_evt_i` is 0. From that edge `sys_rst_o` stays 1 for exactly 66 cycles.
- R3: With `xtal_opt_i`=1 the same hold lasts exactly 5000 cycles.
- R4: If the synchronized external pin is still low when the count expires, `sys_rst_o` stays 1 until the pin goes high. It then drops within 3 cycles of the pin rising.
- R5: While `sys_rst_o` is 1, `gpio_dir_o` is all ones (1 = input) and `gpio_pu_o` is all zeros. Otherwise both outputs pass `cpu_dir_i` and `cpu_pu_i` through unchanged.
- R6: Any system reset returns `clk_sel_o` to 2'b00, whatever value was written before through `clk_sel_we_i`/`clk_sel_wd_i`.
- R7: A one-cycle `stop_wake_i` pulse while running starts a STOP recovery. During it, `wdt_rst_o` and `osc_rst_o` are each high for exactly one cycle and `sys_rst_o` stays 0. `clk_sel_o` returns to 2'b00, the GPIO outputs keep passing the CPU values, and `cpu_hold_o` is 1 until the vector is loaded.
- R8: After release the block issues exactly two reads: address 0x0002 and then address 0x0003. It loads `pc_o` = {byte at 0x0002, byte at 0x0003}, so the high byte comes first.
- R9: `pc_valid_o` is high for exactly one cycle, in the same cycle that `cpu_hold_o` first falls. `pc_o` changes only in that cycle.
- R10: The external pin passes through a two-flop synchronizer. A new falling edge of the pin during the count restarts the count from zero, so `sys_rst_o` is then released about 66 cycles after the new assertion rather than at the original expiry.
- R11: A `lv_evt_i` pulse while running returns the block to reset. The block then waits, holding `sys_rst_o` at 1 with no count and no memory read, for as long as `supply_ok_i` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| arst_n | input | 1 | Asynchronous active-low hard reset |
| supply_ok_i | input | 1 | Supply above POR threshold, synchronous to clk |
| lv_evt_i | input | 1 | Power-on / low-voltage detect flag |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| stop_wake_i | input | 1 | STOP-mode recovery request pulse |
| xtal_opt_i | input | 1 | Crystal enabled option bit (selects long hold) |
| clk_sel_we_i | input | 1 | Write enable for the clock-source select |
| clk_sel_wd_i | input | 2 | Clock-source select write data |
| cpu_dir_i | input | 8 | GPIO direction requested by software (1 = input) |
| cpu_pu_i | input | 8 | GPIO pull-up enables requested by software |
| mem_rdata_i | input | 8 | Program memory read data, one cycle after request |
| sys_rst_o | output | 1 | System reset to CPU and peripherals |
| cpu_hold_o | output | 1 | CPU held until the boot vector is loaded |
| wdt_rst_o | output | 1 | Watchdog-control register reset strobe |
| osc_rst_o | output | 1 | Oscillator-control register reset strobe |
| clk_sel_o | output | 2 | Clock-source select, 2'b00 = internal oscillator |
| gpio_dir_o | output | 8 | GPIO direction to pads |
| gpio_pu_o | output | 8 | GPIO pull-up enables to pads |
| mem_rd_o | output | 1 | Program memory read request |
| mem_addr_o | output | 16 | Program memory read address |
| pc_o | output | 16 | Loaded start address |
| pc_valid_o | output | 1 | One-cycle pulse when pc_o is loaded |

## Verification
The hold path is exercised with the supply rising after a hard reset, once with the crystal bit clear and once with it set. This separates the two hold lengths and shows that no counting happens while the supply is low. An external-pin pulse held well past expiry shows the pin stretching reset. A second short pin pulse landing mid-count shows whether the count restarts or simply runs to its first expiry. A STOP wake pulse, issued after software has set a non-default clock source, separates the light recovery (strobes only, pads untouched) from a full system reset. Each release uses a different boot vector, so swapped bytes or a stale vector show up in the program counter.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    S_WAIT_SUP = 3'd0,
    S_COUNT    = 3'd1,
    S_PIN_HOLD = 3'd2,
    S_FETCH    = 3'd3,
    S_RUN      = 3'd4
  } seq_st_e;

  typedef enum logic [2:0] {
    F_IDLE   = 3'd0,
    F_REQ_HI = 3'd1,
    F_CAP_HI = 3'd2,
    F_REQ_LO = 3'd3,
    F_CAP_LO = 3'd4
  } fetch_st_e;

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int         W         = 1,
  parameter logic [0:0] RESET_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= {W{RESET_VAL}};
      sync_q <= {W{RESET_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int SHORT_CYC = 66,
  parameter int LONG_CYC  = 5000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic long_sel_i,
  output logic expired_o
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;
  logic          cnt_en;

  assign lim       = long_sel_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
  assign expired_o = run_i && !clr_i && (cnt_q >= lim);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run_i && !expired_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q < CW'(LONG_CYC));
endmodule

// File: rtl/rst_vec_fetch.sv
module rst_vec_fetch
  import rstseq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] VEC_ADDR = 16'h0002
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            en_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            mem_rd_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            last_o,
  output logic [2*DW-1:0] pc_o,
  output logic            pc_valid_o
);
  fetch_st_e       st_q, st_d;
  logic [DW-1:0]   hi_q;
  logic [2*DW-1:0] pc_q;
  logic            valid_q;
  logic            hi_en, pc_en;

  always_comb begin
    st_d = st_q;
    if (!en_i) st_d = F_IDLE;
    else begin
      case (st_q)
        F_IDLE:   st_d = F_REQ_HI;
        F_REQ_HI: st_d = F_CAP_HI;
        F_CAP_HI: st_d = F_REQ_LO;
        F_REQ_LO: st_d = F_CAP_LO;
        F_CAP_LO: st_d = F_IDLE;
        default:  st_d = F_IDLE;
      endcase
    end
  end

  assign hi_en      = en_i && (st_q == F_CAP_HI);
  assign pc_en      = en_i && (st_q == F_CAP_LO);
  assign last_o     = pc_en;
  assign mem_rd_o   = en_i && ((st_q == F_REQ_HI) || (st_q == F_REQ_LO));
  assign mem_addr_o = (st_q == F_REQ_LO) ? VEC_ADDR + AW'(1) : VEC_ADDR;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q    <= F_IDLE;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= pc_en;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    hi_q <= '0;
    else if (hi_en) hi_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    pc_q <= '0;
    else if (pc_en) pc_q <= {hi_q, mem_rdata_i};
  end

  assign pc_o       = pc_q;
  assign pc_valid_o = valid_q;

  a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!arst_n)
    pc_valid_o |=> !pc_valid_o);
  a_r9_pc_stable: assert property (@(posedge clk) disable iff (!arst_n)
    !pc_valid_o |-> $stable(pc_o));
  a_r8_lo_after_hi: assert property (@(posedge clk) disable iff (!arst_n)
    (mem_rd_o && mem_addr_o == VEC_ADDR + AW'(1)) |->
      $past(mem_rd_o && mem_addr_o == VEC_ADDR, 2));
endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl
  import rstseq_pkg::*;
#(
  parameter int SHORT_CYC = 66,
  parameter int LONG_CYC  = 5000,
  parameter int N_GPIO    = 8,
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CSW       = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              supply_ok_i,
  input  logic              lv_evt_i,
  input  logic              ext_rst_n_i,
  input  logic              stop_wake_i,
  input  logic              xtal_opt_i,
  input  logic              clk_sel_we_i,
  input  logic [CSW-1:0]    clk_sel_wd_i,
  input  logic [N_GPIO-1:0] cpu_dir_i,
  input  logic [N_GPIO-1:0] cpu_pu_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              sys_rst_o,
  output logic              cpu_hold_o,
  output logic              wdt_rst_o,
  output logic              osc_rst_o,
  output logic [CSW-1:0]    clk_sel_o,
  output logic [N_GPIO-1:0] gpio_dir_o,
  output logic [N_GPIO-1:0] gpio_pu_o,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [2*DW-1:0]   pc_o,
  output logic              pc_valid_o
);
  localparam logic [AW-1:0] VEC_ADDR = AW'(2);

  seq_st_e        st_q, st_d;
  logic           sys_q, sys_d;
  logic           strobe_q, strobe_d;
  logic           pin_s, pin_prev_q, pin_fall, pin_low;
  logic           tmr_clr, tmr_expired;
  logic           fetch_last;
  logic [CSW-1:0] clk_sel_q;
  logic           clk_sel_clr, clk_sel_en;

  rst_sync2 #(.W(1), .RESET_VAL(1'b1)) u_pin_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d_i    (ext_rst_n_i),
    .q_o    (pin_s)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pin_prev_q <= 1'b1;
    else         pin_prev_q <= pin_s;
  end

  assign pin_low  = !pin_s;
  assign pin_fall = pin_prev_q && !pin_s;

  // Sequencer: priority low-voltage > pin > STOP wake
  always_comb begin
    st_d     = st_q;
    sys_d    = sys_q;
    strobe_d = 1'b0;
    tmr_clr  = (st_q != S_COUNT);
    case (st_q)
      S_WAIT_SUP: begin
        if (!lv_evt_i && supply_ok_i) st_d = S_COUNT;
      end
      S_COUNT: begin
        if (lv_evt_i) begin
          st_d = S_WAIT_SUP; sys_d = 1'b1;
        end else if (pin_fall) begin
          tmr_clr = 1'b1; sys_d = 1'b1;
        end else if (stop_wake_i) begin
          tmr_clr = 1'b1;
        end else if (tmr_expired) begin
          st_d = pin_low ? S_PIN_HOLD : S_FETCH;
        end
      end
      S_PIN_HOLD: begin
        if (lv_evt_i) begin
          st_d = S_WAIT_SUP; sys_d = 1'b1;
        end else if (!pin_low) begin
          st_d = S_FETCH;
        end
      end
      S_FETCH: begin
        if (lv_evt_i) begin
          st_d = S_WAIT_SUP; sys_d = 1'b1;
        end else if (pin_low) begin
          st_d = S_COUNT; sys_d = 1'b1;
        end else if (stop_wake_i) begin
          st_d = S_COUNT;
        end else if (fetch_last) begin
          st_d = S_RUN;
        end
      end
      S_RUN: begin
        if (lv_evt_i) begin
          st_d = S_WAIT_SUP; sys_d = 1'b1;
        end else if (pin_low) begin
          st_d = S_COUNT; sys_d = 1'b1;
        end else if (stop_wake_i) begin
          st_d = S_COUNT; sys_d = 1'b0; strobe_d = 1'b1;
        end
      end
      default: begin
        st_d = S_WAIT_SUP; sys_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q     <= S_WAIT_SUP;
      sys_q    <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      sys_q    <= sys_d;
      strobe_q <= strobe_d;
    end
  end

  rst_hold_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk        (clk),
    .arst_n     (arst_n),
    .clr_i      (tmr_clr),
    .run_i      (st_q == S_COUNT),
    .long_sel_i (xtal_opt_i),
    .expired_o  (tmr_expired)
  );

  rst_vec_fetch #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_fetch (
    .clk         (clk),
    .arst_n      (arst_n),
    .en_i        (st_q == S_FETCH),
    .mem_rdata_i (mem_rdata_i),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .last_o      (fetch_last),
    .pc_o        (pc_o),
    .pc_valid_o  (pc_valid_o)
  );

  assign sys_rst_o  = sys_q && ((st_q == S_WAIT_SUP) || (st_q == S_COUNT) ||
                                (st_q == S_PIN_HOLD));
  assign cpu_hold_o = (st_q != S_RUN);
  assign wdt_rst_o  = strobe_q;
  assign osc_rst_o  = strobe_q;

  // Clock-source select register, cleared by system reset or oscillator strobe
  assign clk_sel_clr = sys_rst_o || strobe_q;
  assign clk_sel_en  = clk_sel_clr || clk_sel_we_i;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         clk_sel_q <= '0;
    else if (clk_sel_en) clk_sel_q <= clk_sel_clr ? '0 : clk_sel_wd_i;
  end
  assign clk_sel_o = clk_sel_q;

  // Pad safety during system reset
  assign gpio_dir_o = sys_rst_o ? {N_GPIO{1'b1}} : cpu_dir_i;
  assign gpio_pu_o  = sys_rst_o ? {N_GPIO{1'b0}} : cpu_pu_i;

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_rst_o |=> !wdt_rst_o);
  a_r7_strobe_no_sysrst: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_rst_o |-> !sys_rst_o && cpu_hold_o);
  a_r6_clksel_default: assert property (@(posedge clk) disable iff (!arst_n)
    $past(sys_rst_o) |-> clk_sel_o == '0);
  a_r4_pin_stretch: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == S_PIN_HOLD && pin_low) |=> sys_rst_o);
endmodule

// File: tb/boot_reset_ctrl_tb_top.sv
module boot_reset_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        supply_ok, lv_evt, ext_rst_n, stop_wake, xtal_opt;
  logic        sel_we;
  logic [1:0]  sel_wd;
  logic [7:0]  cpu_dir, cpu_pu;
  logic [7:0]  mem_rdata;
  logic        sys_rst, cpu_hold, wdt_rst, osc_rst, mem_rd, pc_valid;
  logic [1:0]  clk_sel;
  logic [7:0]  gpio_dir, gpio_pu;
  logic [15:0] mem_addr, pc;

  logic [7:0]  vec_hi, vec_lo;
  logic [15:0] exp_q[$];
  logic [15:0] addr_log[$];
  int          nvec = 0;
  int          nbad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  boot_reset_ctrl dut_i (
    .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok), .lv_evt_i(lv_evt),
    .ext_rst_n_i(ext_rst_n), .stop_wake_i(stop_wake), .xtal_opt_i(xtal_opt),
    .clk_sel_we_i(sel_we), .clk_sel_wd_i(sel_wd), .cpu_dir_i(cpu_dir),
    .cpu_pu_i(cpu_pu), .mem_rdata_i(mem_rdata), .sys_rst_o(sys_rst),
    .cpu_hold_o(cpu_hold), .wdt_rst_o(wdt_rst), .osc_rst_o(osc_rst),
    .clk_sel_o(clk_sel), .gpio_dir_o(gpio_dir), .gpio_pu_o(gpio_pu),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .pc_o(pc), .pc_valid_o(pc_valid)
  );

  // Program memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd) begin
      if (mem_addr == 16'h0002)      mem_rdata <= vec_hi;
      else if (mem_addr == 16'h0003) mem_rdata <= vec_lo;
      else                           mem_rdata <= 8'hEE;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on every loaded vector
  always @(negedge clk) begin
    if (arst_n && mem_rd) addr_log.push_back(mem_addr);
    if (arst_n && pc_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected vector", pc, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        chk(pc == e, "R8 pc value", pc, e);
      end
      chk(addr_log.size() == 2, "R8 read count", addr_log.size(), 2);
      if (addr_log.size() == 2) begin
        chk(addr_log[0] == 16'h0002, "R8 first address", addr_log[0], 2);
        chk(addr_log[1] == 16'h0003, "R8 second address", addr_log[1], 3);
      end
      addr_log.delete();
    end
  end

  task automatic expect_vec(input logic [7:0] h, input logic [7:0] l);
    vec_hi = h; vec_lo = l;
    exp_q.push_back({h, l});
  endtask

  task automatic wait_run(input string req);
    int n = 0;
    while (cpu_hold && n < 40) begin @(negedge clk); n++; end
    chk(!cpu_hold, {req, " R9 hold released"}, cpu_hold, 0);
    chk(pc_valid, "R9 done pulse with release", pc_valid, 1);
    @(negedge clk);
    chk(!pc_valid, "R9 done one cycle", pc_valid, 0);
  endtask

  task automatic power_up(input bit xo, input int exp_len, input string req);
    int n = 0;
    xtal_opt  = xo;
    supply_ok = 1'b1;
    @(negedge clk);
    while (sys_rst && n < 10000) begin n++; @(negedge clk); end
    chk(n == exp_len, req, n, exp_len);
    wait_run(req);
  endtask

  initial begin
    arst_n = 0; supply_ok = 0; lv_evt = 0; ext_rst_n = 1; stop_wake = 0;
    xtal_opt = 0; sel_we = 0; sel_wd = 0; cpu_dir = 8'h0F; cpu_pu = 8'hF0;
    vec_hi = 0; vec_lo = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    chk(sys_rst && cpu_hold, "R1 reset outputs", {sys_rst, cpu_hold}, 3);
    chk(clk_sel == 2'b00 && !mem_rd, "R1 clk_sel/mem_rd", {clk_sel, mem_rd}, 0);
    chk(gpio_dir == 8'hFF && gpio_pu == 8'h00, "R5 pads in reset", {gpio_dir, gpio_pu}, 16'hFF00);
    arst_n = 1;
    repeat (20) @(negedge clk);
    chk(sys_rst && !mem_rd, "R11 waits for supply", {sys_rst, mem_rd}, 2);

    // R2: short hold
    expect_vec(8'h12, 8'h34);
    power_up(1'b0, 66, "R2 short hold length");
    chk(gpio_dir == 8'h0F && gpio_pu == 8'hF0, "R5 pads pass-through", {gpio_dir, gpio_pu}, 16'h0FF0);

    // R6 precondition + R4 pin stretch
    sel_we = 1; sel_wd = 2'b10; @(negedge clk); sel_we = 0;
    chk(clk_sel == 2'b10, "R6 clk_sel written", clk_sel, 2);
    expect_vec(8'hA5, 8'h5A);
    ext_rst_n = 0;
    repeat (300) @(negedge clk);
    chk(sys_rst, "R4 reset stretched by pin", sys_rst, 1);
    chk(clk_sel == 2'b00, "R6 clk_sel back to internal", clk_sel, 0);
    ext_rst_n = 1;
    begin
      int n = 0;
      @(negedge clk);
      while (sys_rst && n < 100) begin n++; @(negedge clk); end
      chk(n <= 3, "R4 release after pin", n, 3);
    end
    wait_run("R4");

    // R10 restart on new pin edge during count
    expect_vec(8'h0B, 8'hC0);
    ext_rst_n = 0; repeat (4) @(negedge clk); ext_rst_n = 1;
    repeat (30) @(negedge clk);
    chk(sys_rst, "R10 counting", sys_rst, 1);
    ext_rst_n = 0; repeat (4) @(negedge clk); ext_rst_n = 1;
    begin
      int n = 4;
      while (sys_rst && n < 500) begin n++; @(negedge clk); end
      chk(n >= 66 && n <= 70, "R10 count restarted", n, 68);
    end
    wait_run("R10");

    // R7 STOP recovery
    sel_we = 1; sel_wd = 2'b01; @(negedge clk); sel_we = 0;
    expect_vec(8'h7E, 8'h81);
    stop_wake = 1; @(negedge clk); stop_wake = 0;
    begin
      int ws = 0, os = 0, sr = 0, pads = 0;
      if (wdt_rst) ws++;
      if (osc_rst) os++;
      for (int i = 0; i < 60; i++) begin
        if (sys_rst) sr++;
        if (gpio_dir != 8'h0F || gpio_pu != 8'hF0) pads++;
        @(negedge clk);
        if (wdt_rst) ws++;
        if (osc_rst) os++;
      end
      chk(ws == 1 && os == 1, "R7 strobes single", {ws[7:0], os[7:0]}, 16'h0101);
      chk(sr == 0, "R7 no system reset", sr, 0);
      chk(pads == 0, "R7 pads untouched", pads, 0);
      chk(cpu_hold, "R7 cpu held", cpu_hold, 1);
      chk(clk_sel == 2'b00, "R7 clk_sel cleared", clk_sel, 0);
    end
    wait_run("R7");

    // R11 low-voltage event, then R3 long hold
    expect_vec(8'hCA, 8'hFE);
    supply_ok = 0; lv_evt = 1; @(negedge clk); lv_evt = 0;
    repeat (300) @(negedge clk);
    chk(sys_rst && cpu_hold && addr_log.size() == 0, "R11 held without supply",
        {sys_rst, cpu_hold}, 3);
    power_up(1'b1, 5000, "R3 long hold length");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all vectors loaded", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule